// File: doc/BRIEF.md
# Reed-Muller Spectrum Butterfly Engine

This block turns the truth table of an n-variable Boolean function into its positive-polarity Reed-Muller coefficient vector. The truth table arrives as a 2^n-bit word on a load strobe. A start pulse then runs n XOR butterfly stages, one per clock. Each stage applies the positive Davio expansion on one variable, so the function becomes f = f0 XOR x·(f0 XOR f1). At the end the working register holds the XOR sum of monomials, with one 0/1 coefficient per monomial.

Bit i of the truth table is the function value at the input assignment whose variable k equals bit k of i. Bit m of the result is the coefficient of the monomial formed by the variables whose bits are set in m; bit 0 is the constant term. A single-cycle done pulse marks the end of a run. The result stays in place until the next load or start. The transform is its own inverse, so starting a second run without a new load gives back the original truth table.

Top module: `rm_spectrum_engine`

## Requirements
- R1: During and after an active-low reset, coef_o is all zeros and busy_o and done_o are 0.
- R2: A load_i sampled high while busy_o is 0 puts tt_i on coef_o from the following cycle.
- R3: A start_i sampled high while idle and without load_i holds busy_o high for exactly NVARS cycles. done_o is high for exactly the one cycle after the last stage and for no other cycle.
- R4: When a run ends, coef_o bit m equals the XOR of the loaded truth-table bits i for all i whose set bits are a subset of the set bits of m.
- R5: Stages run for k = 0 up to NVARS-1, one per cycle. Stage k pairs the entries whose indices differ only in bit k. In each pair the entry with bit k clear is unchanged and the entry with bit k set becomes the XOR of both, and coef_o shows the value after each stage.
- R6: load_i and start_i are ignored while busy_o is 1: the run finishes with the same result and the same timing.
- R7: When load_i and start_i are high in the same idle cycle, the load is taken and no run begins.
- R8: While idle, with load_i and start_i both low, coef_o keeps its value.
- R9: Two runs after one load return coef_o to the loaded truth table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture tt_i into the working register |
| tt_i | input | 2**NVARS | Truth-table vector, bit i = f at assignment i |
| start_i | input | 1 | Begin a transform of the working register |
| coef_o | output | 2**NVARS | Working register: coefficients once a run ends |
| busy_o | output | 1 | A transform is in progress |
| done_o | output | 1 | One-cycle pulse after the last stage |

## Verification
On every cycle the assertions check the timing contract: how long busy lasts, that done is a lone pulse following the fall of busy, that load capture works and that load beats start, and that the result holds steady while idle. The values of the coefficients can only be shown by the bench. It compares every output bit with a subset-XOR reference over a table of known functions and a pseudo-random sweep. It also checks the partial vector after stage 0, the two-run round trip, and that strobes during a run have no effect.

// File: rtl/rm_pkg.sv
package rm_pkg;
  // width of a counter that can hold 0..n-1 (at least one bit)
  function automatic int unsigned rm_idx_w(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rm_butterfly_stage.sv
module rm_butterfly_stage #(
  parameter int unsigned NVARS = 4,
  parameter int unsigned K     = 0
) (
  input  logic [(2**NVARS)-1:0] vec_i,
  output logic [(2**NVARS)-1:0] vec_o
);
  localparam int unsigned SIZE = 2 ** NVARS;
  localparam int unsigned DIST = 2 ** K;

  for (genvar i = 0; i < SIZE; i++) begin : g_lane
    if (((i / DIST) % 2) == 1) begin : g_upper
      assign vec_o[i] = vec_i[i] ^ vec_i[i - DIST];
    end else begin : g_lower
      assign vec_o[i] = vec_i[i];
    end
  end
endmodule

// File: rtl/rm_stage_seq.sv
module rm_stage_seq #(
  parameter int unsigned NVARS = 4,
  parameter int unsigned SW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          start_i,
  output logic [SW-1:0] stage_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          capture_o
);
  localparam logic [SW-1:0] LAST = SW'(NVARS - 1);

  logic          busy_q, done_q;
  logic [SW-1:0] stage_q;
  logic          launch;

  assign capture_o = load_i & ~busy_q;
  assign launch    = start_i & ~load_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stage_q <= '0;
    end else if (busy_q) begin
      if (stage_q == LAST) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        stage_q <= '0;
      end else begin
        stage_q <= stage_q + 1'b1;
      end
    end else begin
      done_q  <= 1'b0;
      stage_q <= '0;
      if (launch) busy_q <= 1'b1;
    end
  end

  assign stage_o = stage_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/rm_spectrum_engine.sv
module rm_spectrum_engine #(
  parameter int unsigned NVARS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [(2**NVARS)-1:0] tt_i,
  input  logic                  start_i,
  output logic [(2**NVARS)-1:0] coef_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int unsigned SIZE  = 2 ** NVARS;
  localparam int unsigned SW    = rm_pkg::rm_idx_w(NVARS);
  localparam int unsigned SLOTS = 2 ** SW;

  logic [SW-1:0]   stage;
  logic            busy, capture;
  logic [SIZE-1:0] work_q;
  logic [SIZE-1:0] stage_vec [SLOTS];

  rm_stage_seq #(.NVARS(NVARS), .SW(SW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .start_i  (start_i),
    .stage_o  (stage),
    .busy_o   (busy),
    .done_o   (done_o),
    .capture_o(capture)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_stage
    if (k < NVARS) begin : g_real
      rm_butterfly_stage #(.NVARS(NVARS), .K(k)) u_bfly (
        .vec_i(work_q),
        .vec_o(stage_vec[k])
      );
    end else begin : g_pad
      assign stage_vec[k] = work_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      work_q <= '0;
    else if (capture) work_q <= tt_i;
    else if (busy)    work_q <= stage_vec[stage];
  end

  assign coef_o = work_q;
  assign busy_o = busy;
endmodule

// File: rtl/rm_spectrum_checker.sv
module rm_spectrum_checker #(
  parameter int unsigned NVARS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  load_i,
  input logic [(2**NVARS)-1:0] tt_i,
  input logic                  start_i,
  input logic [(2**NVARS)-1:0] coef_o,
  input logic                  busy_o,
  input logic                  done_o
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 8'd1;
    else             busy_cnt <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && coef_o == '0));

  assert_load_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o) |=> (coef_o == $past(tt_i)));

  assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == 8'(NVARS)));

  assert_done_after_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_runs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && busy_cnt < 8'(NVARS - 1)) |=> busy_o);

  assert_load_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && start_i && !busy_o) |=> !busy_o);

  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load_i && !start_i) |=> $stable(coef_o));
endmodule

bind rm_spectrum_engine rm_spectrum_checker #(.NVARS(NVARS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .tt_i   (tt_i),
  .start_i(start_i),
  .coef_o (coef_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/sim_rm_spectrum_engine.sv
`timescale 1ns/100ps
module sim_rm_spectrum_engine;
  localparam int unsigned N    = 4;
  localparam int unsigned SIZE = 16;
  localparam int unsigned NVEC = 8;
  // {truth table, expected coefficients}
  localparam logic [31:0] VEC_TAB [NVEC] = '{
    {16'h0000, 16'h0000},  // constant 0
    {16'hFFFF, 16'h0001},  // constant 1
    {16'hAAAA, 16'h0002},  // x0
    {16'h8888, 16'h0008},  // x0 x1
    {16'h6666, 16'h0006},  // x0 ^ x1
    {16'hEEEE, 16'h000E},  // x0 | x1
    {16'h0001, 16'hFFFF},  // minterm 0
    {16'h8000, 16'h8000}   // minterm 15
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, start = 1'b0;
  logic [SIZE-1:0] tt = '0;
  logic [SIZE-1:0] coef;
  logic busy, done;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rm_spectrum_engine #(.NVARS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .tt_i(tt),
    .start_i(start), .coef_o(coef), .busy_o(busy), .done_o(done)
  );

  function automatic logic [SIZE-1:0] ref_rm(logic [SIZE-1:0] t);
    logic [SIZE-1:0] r = '0;
    for (int m = 0; m < SIZE; m++)
      for (int i = 0; i < SIZE; i++)
        if ((i & m) == i) r[m] = r[m] ^ t[i];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(logic [SIZE-1:0] v);
    load = 1'b1; tt = v; tick(1); load = 1'b0;
  endtask

  // start, then sample at the cycle after the last stage
  task automatic do_run();
    start = 1'b1; tick(1); start = 1'b0;
    tick(N);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [SIZE-1:0] lfsr;
    tick(3);
    check("R1 coef in reset", 32'(coef), 32'h0);
    check("R1 busy/done in reset", {30'b0, busy, done}, 32'h0);
    rst_n = 1'b1;
    tick(2);
    check("R1 idle after reset", {30'b0, busy, done}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      do_load(VEC_TAB[v][31:16]);
      check("R2 load capture", 32'(coef), 32'(VEC_TAB[v][31:16]));
      do_run();
      check("R3 done after run", 32'(done), 32'h1);
      check("R4 table coefficients", 32'(coef), 32'(VEC_TAB[v][15:0]));
      tick(1);
      check("R3 done single pulse", 32'(done), 32'h0);
    end

    // R5: partial vector after stage 0, busy span
    do_load(16'h0001);
    start = 1'b1; tick(1); start = 1'b0;
    check("R3 busy after start", 32'(busy), 32'h1);
    tick(1);
    check("R5 after stage 0", 32'(coef), 32'h0003);
    tick(1);
    check("R5 after stage 1", 32'(coef), 32'h000F);
    tick(N - 2);
    check("R3 busy low at end", 32'(busy), 32'h0);
    check("R5 final", 32'(coef), 32'hFFFF);

    // R8: idle hold
    tick(5);
    check("R8 idle stable", 32'(coef), 32'hFFFF);

    // R9: involution
    do_load(16'h3C5A);
    do_run();
    check("R9 first run", 32'(coef), 32'(ref_rm(16'h3C5A)));
    tick(1);
    do_run();
    check("R9 second run restores", 32'(coef), 32'h3C5A);
    tick(1);

    // R6: strobes during a run ignored
    do_load(16'h8888);
    start = 1'b1; tick(1); start = 1'b0;
    load = 1'b1; tt = 16'h1234; start = 1'b1; tick(2);
    load = 1'b0; start = 1'b0;
    tick(N - 2);
    check("R6 done timing unchanged", 32'(done), 32'h1);
    check("R6 result unchanged", 32'(coef), 32'h0008);
    tick(1);

    // R7: load beats start
    load = 1'b1; start = 1'b1; tt = 16'h00F0; tick(1);
    load = 1'b0; start = 1'b0;
    check("R7 load taken", 32'(coef), 32'h00F0);
    check("R7 no run started", 32'(busy), 32'h0);
    tick(N + 1);
    check("R7 no done", 32'(done), 32'h0);
    check("R7 value held", 32'(coef), 32'h00F0);

    // R4: pseudo-random sweep against subset-XOR reference
    lfsr = 16'hACE1;
    for (int s = 0; s < 400; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_load(lfsr);
      do_run();
      check("R4 sweep", 32'(coef), 32'(ref_rm(lfsr)));
      tick(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule